// File: doc/BRIEF.md
# Single-Port SDRAM Controller with Explicit Row Closing

This block connects a simple word-wide request port to one SDRAM device. A requester presents an address made of bank, row and column fields, raises a read or a write strobe, and holds it until the wait flag drops. The controller then opens the row and issues the column command. It waits for the write-recovery time, or until the read data has been captured. Finally it closes the row with an explicit precharge and waits out the precharge time. Read data returns one word at a time, qualified by a single-cycle valid strobe. Auto-precharge is never used.

After reset the controller drives NOP for a power-up interval. It then precharges all banks and issues a configurable number of auto-refresh commands. Next it programs the mode register with the CAS latency and a burst length of one. Only after that does it accept requests. A refresh timer then raises a refresh request at a fixed interval. A pending refresh is served at the next idle point, ahead of any user request.

Every timing parameter is given in nanoseconds together with the clock frequency in MHz. Minimum delays are rounded up to whole clocks. The refresh interval is rounded down, so that refresh is never late. The data bus is split into an output word, an output enable for the pad buffer and an input word.

Top module: `sdram_ctrl`

## Requirements
- R1: During and right after reset, the command pins carry NOP, the data output enable is low and the wait flag is high.
- R2: After reset the controller drives NOP for at least ceil(POWERUP_NS·CLK_MHZ/1000) cycles. It then issues PRECHARGE with A10 high, then exactly INIT_REFS AUTO REFRESH commands, then LOAD MODE with A[6:4] = CAS latency and A[3:0] = 0. No ACTIVE is issued before LOAD MODE.
- R3: Command spacing, in cycles rounded up from nanoseconds, is never shorter than the following: t_RCD from ACTIVE to READ/WRITE, t_RP after any PRECHARGE, t_RFC after any AUTO REFRESH, and t_WR from WRITE to its PRECHARGE.
- R4: With no user traffic, successive AUTO REFRESH commands are exactly floor(REFRESH_NS·CLK_MHZ/1000) cycles apart.
- R5: A due refresh is served ahead of a waiting request. The wait flag is high in the cycle of every AUTO REFRESH. Under traffic, the gap between refreshes exceeds the interval by at most one access.
- R6: The request address is split as {bank, row, column}, column in the low bits. Each access is ACTIVE(bank, row), then READ or WRITE(same bank, column on the low A bits, A10 low), then PRECHARGE(same bank, A10 low). The encodings on {CS#,RAS#,CAS#,WE#} are: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R7: Read data is sampled CAS-latency cycles after the READ cycle. The valid strobe is high for exactly one cycle, CAS latency + 1 cycles after the READ cycle, carrying the addressed word.
- R8: In the WRITE cycle, DQM equals the inverted byte enables. Bytes whose enable is low keep their previous content.
- R9: The data output enable is high in exactly the WRITE command cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | BA_W+ROW_W+COL_W | Word address {bank, row, column} |
| req_read | input | 1 | Read strobe, held until accepted |
| req_write | input | 1 | Write strobe, held until accepted |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_wait | output | 1 | High while a request cannot be accepted |
| rsp_rdata | output | DATA_W | Read data |
| rsp_valid | output | 1 | One-cycle strobe qualifying rsp_rdata |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_a | output | ROW_W | Multiplexed row/column/mode address |
| sd_dqm | output | DATA_W/8 | Data masks, active high |
| sd_dq_o | output | DATA_W | Data to the pad buffer |
| sd_dq_oe | output | 1 | Pad buffer output enable |
| sd_dq_i | input | DATA_W | Data from the pad buffer |

## Verification
A behavioural SDRAM model answers reads after the configured CAS latency and applies DQM on writes. Directed accesses go to the all-zero and the all-ones address, with single-byte masks, so that bank, row and column field placement and byte-lane masking are told apart. A seeded random mix of reads and writes over a small address pool hits the same rows and different banks, with random byte enables, and checks every returned word against a shadow copy. That traffic runs across refresh deadlines, which separates correct refresh priority from refreshes that slip. A final quiet stretch measures the refresh spacing exactly, which exposes a refresh count rounded up instead of down.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  // minimum delay: round up, never below one cycle
  function automatic int cyc_min(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // deadline interval: round down so the deadline is never missed
  function automatic int cyc_max(input int ns, input int mhz);
    int c;
    c = (ns * mhz) / 1000;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
`timescale 1ns/1ps
module sdc_refresh_timer #(
  parameter int PERIOD = 3125,
  parameter int W      = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic due
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= W'(PERIOD - 1);
      due <= 1'b0;
    end else if (cnt == '0) begin
      cnt <= W'(PERIOD - 1);
      due <= 1'b1;
    end else begin
      cnt <= cnt - W'(1);
      due <= 1'b0;
    end
  end

  // R4: the due pulse is one cycle wide
  a_r4_due_single: assert property (@(posedge clk) disable iff (rst) due |=> !due);

endmodule

// File: rtl/sdc_read_capture.sv
`timescale 1ns/1ps
module sdc_read_capture #(
  parameter int CAS_LAT = 3,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_on_pins,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata,
  output logic              valid
);

  logic [CAS_LAT-1:0] stg;

  generate
    if (CAS_LAT == 1) begin : g_cl1
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= rd_on_pins;
      end
    end else begin : g_cln
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[CAS_LAT-2:0], rd_on_pins};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      rdata <= '0;
    end else begin
      valid <= stg[CAS_LAT-1];
      if (stg[CAS_LAT-1]) rdata <= dq_i;
    end
  end

  // R7: single-word reads give one-cycle strobes
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst) valid |=> !valid);

endmodule

// File: rtl/sdc_sequencer.sv
`timescale 1ns/1ps
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COL_W     = 8,
  parameter int ROW_W     = 12,
  parameter int BA_W      = 2,
  parameter int CAS_LAT   = 3,
  parameter int INIT_REFS = 2,
  parameter int PWR_C     = 20000,
  parameter int TRP_C     = 4,
  parameter int TRFC_C    = 14,
  parameter int TRCD_C    = 4,
  parameter int TWR_C     = 3,
  parameter int CNT_W     = 15,
  localparam int ADDR_W   = BA_W + ROW_W + COL_W,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              ref_due,
  output logic              req_wait,
  output logic              init_done,
  output sd_cmd_e           cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ROW_W-1:0]  a_q,
  output logic [BE_W-1:0]   dqm_q,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  localparam int MRD_C = 2;

  typedef enum logic [3:0] {
    ST_PWR, ST_IRP, ST_IRFC, ST_IMRD, ST_IDLE, ST_RFC, ST_RCD, ST_HOLD, ST_RP
  } st_e;

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        refs_left;
  logic              ref_pend;
  logic              lat_wr;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [BE_W-1:0]   lat_be;
  logic              cnt_done;

  assign cnt_done = (cnt == '0);
  assign req_wait = (st != ST_IDLE) || ref_pend;

  always_ff @(posedge clk) begin
    if (rst) init_done <= 1'b0;
    else if (st == ST_IDLE) init_done <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      cnt       <= CNT_W'(PWR_C - 1);
      refs_left <= '0;
      ref_pend  <= 1'b0;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      a_q       <= '0;
      dqm_q     <= '1;
      dq_o      <= '0;
      dq_oe     <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      dq_oe <= 1'b0;
      case (st)
        ST_PWR: begin
          if (cnt_done) begin
            cmd_q     <= CMD_PRE;
            a_q       <= '0;
            a_q[10]   <= 1'b1;
            refs_left <= 4'(INIT_REFS);
            cnt       <= CNT_W'(TRP_C - 1);
            st        <= ST_IRP;
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_IRP: begin
          if (cnt_done) begin
            cmd_q     <= CMD_REF;
            refs_left <= refs_left - 4'd1;
            cnt       <= CNT_W'(TRFC_C - 1);
            st        <= ST_IRFC;
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_IRFC: begin
          if (cnt_done) begin
            if (refs_left != '0) begin
              cmd_q     <= CMD_REF;
              refs_left <= refs_left - 4'd1;
              cnt       <= CNT_W'(TRFC_C - 1);
            end else begin
              cmd_q    <= CMD_LMR;
              ba_q     <= '0;
              a_q      <= '0;
              a_q[6:4] <= 3'(CAS_LAT);
              cnt      <= CNT_W'(MRD_C - 1);
              st       <= ST_IMRD;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_IMRD: begin
          if (cnt_done) st <= ST_IDLE;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q    <= CMD_REF;
            ref_pend <= 1'b0;
            cnt      <= CNT_W'(TRFC_C - 1);
            st       <= ST_RFC;
          end else if (req_read || req_write) begin
            cmd_q     <= CMD_ACT;
            ba_q      <= req_addr[ADDR_W-1 -: BA_W];
            a_q       <= req_addr[COL_W +: ROW_W];
            lat_addr  <= req_addr;
            lat_wr    <= req_write;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
            cnt       <= CNT_W'(TRCD_C - 1);
            st        <= ST_RCD;
          end
        end
        ST_RFC, ST_RP: begin
          if (cnt_done) st <= ST_IDLE;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_RCD: begin
          if (cnt_done) begin
            a_q              <= '0;
            a_q[COL_W-1:0]   <= lat_addr[COL_W-1:0];
            if (lat_wr) begin
              cmd_q <= CMD_WR;
              dq_o  <= lat_wdata;
              dq_oe <= 1'b1;
              dqm_q <= ~lat_be;
              cnt   <= CNT_W'(TWR_C - 1);
            end else begin
              cmd_q <= CMD_RD;
              dqm_q <= '0;
              cnt   <= CNT_W'(CAS_LAT - 1);
            end
            st <= ST_HOLD;
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_HOLD: begin
          if (cnt_done) begin
            cmd_q <= CMD_PRE;
            a_q   <= '0;
            cnt   <= CNT_W'(TRP_C - 1);
            st    <= ST_RP;
          end else cnt <= cnt - CNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
      if (ref_due) ref_pend <= 1'b1;
    end
  end

  // spacing tracker for the timing properties
  logic [15:0] gap;
  sd_cmd_e     prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      prev <= CMD_NOP;
    end else if (cmd_q != CMD_NOP) begin
      gap  <= 16'd1;
      prev <= cmd_q;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  // R3
  a_r3_trcd: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (prev == CMD_ACT && gap >= 16'(TRCD_C)));
  a_r3_trp: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP && prev == CMD_PRE) |-> gap >= 16'(TRP_C));
  a_r3_trfc: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP && prev == CMD_REF) |-> gap >= 16'(TRFC_C));
  a_r3_twr: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE && prev == CMD_WR) |-> gap >= 16'(TWR_C));
  // R5
  a_r5_refresh_first: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ref_pend) |=> cmd_q == CMD_REF);
  // R9
  a_r9_oe_on_write: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> cmd_q == CMD_WR);
  // R2
  a_r2_no_early_act: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT) |-> init_done);

endmodule

// File: rtl/sdram_ctrl.sv
`timescale 1ns/1ps
module sdram_ctrl
  import sdc_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int DATA_W     = 16,
  parameter int COL_W      = 8,
  parameter int ROW_W      = 12,
  parameter int BA_W       = 2,
  parameter int CAS_LAT    = 3,
  parameter int INIT_REFS  = 2,
  parameter int POWERUP_NS = 100000,
  parameter int REFRESH_NS = 15625,
  parameter int TRFC_NS    = 70,
  parameter int TRP_NS     = 20,
  parameter int TRCD_NS    = 20,
  parameter int TWR_NS     = 14,
  localparam int ADDR_W    = BA_W + ROW_W + COL_W,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_wait,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_valid,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_i
);

  localparam int PWR_C  = cyc_min(POWERUP_NS, CLK_MHZ);
  localparam int REFI_C = cyc_max(REFRESH_NS, CLK_MHZ);
  localparam int TRFC_C = cyc_min(TRFC_NS, CLK_MHZ);
  localparam int TRP_C  = cyc_min(TRP_NS, CLK_MHZ);
  localparam int TRCD_C = cyc_min(TRCD_NS, CLK_MHZ);
  localparam int TWR_C  = cyc_min(TWR_NS, CLK_MHZ);
  localparam int MAXW_C = imax(imax(PWR_C, TRFC_C), imax(imax(TRP_C, TRCD_C), imax(TWR_C, CAS_LAT)));
  localparam int CNT_W  = $clog2(MAXW_C + 1);
  localparam int TMR_W  = $clog2(REFI_C + 1);

  sd_cmd_e cmd;
  logic    init_done;
  logic    ref_due;

  sdc_refresh_timer #(.PERIOD(REFI_C), .W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .run(init_done), .due(ref_due)
  );

  sdc_sequencer #(
    .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W), .BA_W(BA_W),
    .CAS_LAT(CAS_LAT), .INIT_REFS(INIT_REFS), .PWR_C(PWR_C), .TRP_C(TRP_C),
    .TRFC_C(TRFC_C), .TRCD_C(TRCD_C), .TWR_C(TWR_C), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_read(req_read),
    .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .ref_due(ref_due), .req_wait(req_wait), .init_done(init_done),
    .cmd_q(cmd), .ba_q(sd_ba), .a_q(sd_a), .dqm_q(sd_dqm),
    .dq_o(sd_dq_o), .dq_oe(sd_dq_oe)
  );

  sdc_read_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rd_on_pins(cmd == CMD_RD), .dq_i(sd_dq_i),
    .rdata(rsp_rdata), .valid(rsp_valid)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: tb/sdram_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_ctrl_tb;

  localparam int MHZ = 200, DW = 16, CW = 8, RW = 12, BW = 2, CL = 2, NREF = 3;
  localparam int PWR_NS = 2000, REFI_NS = 3003, TRFC_NS = 70, TRP_NS = 20, TRCD_NS = 20, TWR_NS = 14;
  localparam int AW = BW + RW + CW, BEW = DW / 8;

  function automatic int up_cyc(input int ns); return (ns * MHZ + 999) / 1000; endfunction
  function automatic int dn_cyc(input int ns); return (ns * MHZ) / 1000; endfunction

  localparam int E_PWR = up_cyc(PWR_NS), E_REFI = dn_cyc(REFI_NS), E_RFC = up_cyc(TRFC_NS);
  localparam int E_RP = up_cyc(TRP_NS), E_RCD = up_cyc(TRCD_NS), E_WR = up_cyc(TWR_NS);

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_read = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [BEW-1:0] req_be = '0;
  logic req_wait, rsp_valid, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [BW-1:0] ba;
  logic [RW-1:0] a;
  logic [BEW-1:0] dqm;

  always #2.5 clk = ~clk;

  sdram_ctrl #(
    .CLK_MHZ(MHZ), .DATA_W(DW), .COL_W(CW), .ROW_W(RW), .BA_W(BW), .CAS_LAT(CL),
    .INIT_REFS(NREF), .POWERUP_NS(PWR_NS), .REFRESH_NS(REFI_NS), .TRFC_NS(TRFC_NS),
    .TRP_NS(TRP_NS), .TRCD_NS(TRCD_NS), .TWR_NS(TWR_NS)
  ) u_dut (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_read(req_read), .req_write(req_write),
    .req_wdata(req_wdata), .req_be(req_be), .req_wait(req_wait), .rsp_rdata(rsp_rdata),
    .rsp_valid(rsp_valid), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_a(a), .sd_dqm(dqm), .sd_dq_o(dq_o), .sd_dq_oe(dq_oe), .sd_dq_i(dq_i)
  );

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model and monitor, both on the falling edge
  logic [DW-1:0] mem [int];
  logic [RW-1:0] open_row [4];
  logic [DW-1:0] pipe_d [4];
  assign dq_i = pipe_d[CL];

  int cyc = 0, rel_cyc = 0, n_init_ref = 0, n_ref = 0, max_tr_gap = 0;
  int ref_t [256];
  bit rel = 0, first_cmd_seen = 0, lmr_seen = 0, traffic = 0;
  int t_prev = 0, t_act = 0, t_rd = 0;
  logic [3:0] c_prev = 4'b0111;
  logic [AW-1:0] cur_addr = '0;
  logic [BEW-1:0] cur_be = '0;
  bit ex_pend = 0;
  logic [DW-1:0] ex_data = '0;

  always @(negedge clk) begin
    logic [3:0] c;
    int key;
    c = {cs_n, ras_n, cas_n, we_n};
    cyc++;
    for (int i = 3; i > 0; i--) pipe_d[i] = pipe_d[i-1];
    pipe_d[0] = '0;
    if (rel && !rst) begin
      // R9
      if (dq_oe || c == C_WR) chk(dq_oe && c == C_WR, "R9 oe only in WRITE", {60'd0, c}, C_WR);
      if (c != C_NOP) begin
        if (!first_cmd_seen) begin
          first_cmd_seen = 1;
          chk(c == C_PRE && a[10], "R2 first cmd precharge-all", {a, c}, {1'b1, C_PRE});
          chk(cyc - rel_cyc >= E_PWR, "R2 power-up wait", cyc - rel_cyc, E_PWR);
        end
        if (c_prev == C_PRE) chk(cyc - t_prev >= E_RP, "R3 tRP", cyc - t_prev, E_RP);
        if (c_prev == C_REF) chk(cyc - t_prev >= E_RFC, "R3 tRFC", cyc - t_prev, E_RFC);
        if (c_prev == C_WR && c == C_PRE) chk(cyc - t_prev >= E_WR, "R3 tWR", cyc - t_prev, E_WR);
        case (c)
          C_REF: begin
            if (!lmr_seen) n_init_ref++;
            else begin
              chk(req_wait, "R5 wait high during refresh", req_wait, 1);
              if (n_ref > 0 && traffic && cyc - ref_t[n_ref-1] > max_tr_gap) max_tr_gap = cyc - ref_t[n_ref-1];
              if (n_ref < 256) ref_t[n_ref] = cyc;
              n_ref++;
            end
          end
          C_LMR: begin
            lmr_seen = 1;
            chk(n_init_ref == NREF, "R2 init refresh count", n_init_ref, NREF);
            chk(a[6:4] == 3'(CL) && a[3:0] == 4'd0, "R2 mode word", a[6:0], CL << 4);
          end
          C_ACT: begin
            chk(lmr_seen, "R2 no access before mode load", lmr_seen, 1);
            chk(ba == cur_addr[AW-1 -: BW] && a == cur_addr[CW +: RW], "R6 active bank/row",
                {ba, a}, {cur_addr[AW-1 -: BW], cur_addr[CW +: RW]});
            open_row[ba] = a;
            t_act = cyc;
          end
          C_RD, C_WR: begin
            chk(cyc - t_act >= E_RCD, "R3 tRCD", cyc - t_act, E_RCD);
            chk(ba == cur_addr[AW-1 -: BW] && a[CW-1:0] == cur_addr[CW-1:0] && !a[10],
                "R6 column cmd", {ba, a}, {cur_addr[AW-1 -: BW], cur_addr[CW-1:0]});
            key = int'({ba, open_row[ba], a[CW-1:0]});
            if (c == C_RD) begin
              pipe_d[0] = mem.exists(key) ? mem[key] : '0;
              t_rd = cyc;
            end else begin
              logic [DW-1:0] w;
              chk(dqm == ~cur_be, "R8 dqm inverted enables", dqm, ~cur_be);
              w = mem.exists(key) ? mem[key] : '0;
              for (int b = 0; b < BEW; b++) if (!dqm[b]) w[8*b +: 8] = dq_o[8*b +: 8];
              mem[key] = w;
            end
          end
          C_PRE: if (lmr_seen)
            chk(!a[10] && ba == cur_addr[AW-1 -: BW], "R6 precharge same bank", {ba, a[10]}, {cur_addr[AW-1 -: BW], 1'b0});
          default: ;
        endcase
        t_prev = cyc;
        c_prev = c;
      end
      if (rsp_valid) begin
        chk(ex_pend, "R7 unexpected valid", 0, 1);
        chk(cyc - t_rd == CL + 1, "R7 read latency", cyc - t_rd, CL + 1);
        chk(rsp_rdata == ex_data, "R7 read data", rsp_rdata, ex_data);
        ex_pend = 0;
      end
    end
  end

  // shadow of what the memory should hold
  logic [DW-1:0] shadow [int];

  task automatic access(input bit wr, input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic [BEW-1:0] be);
    @(negedge clk);
    req_addr = ad; req_wdata = d; req_be = be; req_write = wr; req_read = !wr;
    cur_addr = ad; cur_be = be;
    if (!wr) begin
      ex_data = shadow.exists(int'(ad)) ? shadow[int'(ad)] : '0;
      ex_pend = 1;
    end else begin
      logic [DW-1:0] w;
      w = shadow.exists(int'(ad)) ? shadow[int'(ad)] : '0;
      for (int b = 0; b < BEW; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
      shadow[int'(ad)] = w;
    end
    while (req_wait) @(negedge clk);
    @(negedge clk);
    req_read = 0; req_write = 0;
    if (!wr) while (ex_pend) @(negedge clk);
    else repeat (E_WR + E_RP + 2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [AW-1:0] pool [8];
  initial begin
    int unsigned sd;
    int k0;
    sd = $urandom(32'h1F2E3D4C);
    for (int i = 0; i < 4; i++) pipe_d[i] = '0;
    repeat (4) @(negedge clk);
    // R1: state while held in reset
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 nop in reset", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(!dq_oe && req_wait, "R1 oe low, wait high", {dq_oe, req_wait}, 2'b01);
    rst = 0; rel = 1; rel_cyc = cyc + 1;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP && req_wait, "R1 after release", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    while (req_wait) @(negedge clk);
    chk(lmr_seen, "R2 init done before accept", lmr_seen, 1);
    traffic = 1;
    // directed corners: field placement and byte lanes
    access(1, '0, 16'hA55A, 2'b11);
    access(1, '1, 16'h1234, 2'b11);
    access(0, '0, 0, 2'b11);
    access(0, '1, 0, 2'b11);
    access(1, '1, 16'hFFEE, 2'b01);   // R8 low byte only
    access(0, '1, 0, 2'b11);
    access(1, '1, 16'h77FF, 2'b10);   // R8 high byte only
    access(0, '1, 0, 2'b11);
    for (int i = 0; i < 8; i++) begin
      pool[i] = AW'($urandom());
      if (i % 2 == 1) pool[i][AW-1 -: BW] = ~pool[i-1][AW-1 -: BW];
      if (i % 4 == 2) pool[i][CW +: RW] = pool[0][CW +: RW];
    end
    for (int n = 0; n < 120; n++) begin
      logic [AW-1:0] ad;
      ad = pool[$urandom_range(7)];
      if ($urandom_range(1) == 1) access(1, ad, DW'($urandom()), BEW'($urandom_range(3)));
      else access(0, ad, 0, 2'b11);
    end
    traffic = 0;
    // R5: refresh never slips more than one access under load
    chk(n_ref >= 2 && max_tr_gap <= E_REFI + 24, "R5 refresh gap under traffic", max_tr_gap, E_REFI);
    // R4: exact spacing when idle
    repeat (30) @(negedge clk);
    k0 = n_ref;
    while (n_ref < k0 + 3) @(negedge clk);
    chk(ref_t[k0+1] - ref_t[k0] == E_REFI, "R4 refresh interval", ref_t[k0+1] - ref_t[k0], E_REFI);
    chk(ref_t[k0+2] - ref_t[k0+1] == E_REFI, "R4 refresh interval", ref_t[k0+2] - ref_t[k0+1], E_REFI);
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule